// File: doc/BRIEF.md
# Integer Compare and T-Flag Unit

This block evaluates one 32-bit integer operation per cycle and keeps a single condition flag, T, in a register. Some operations produce a result word: add with carry in, add with signed-overflow detection, and decrement-and-test. Others only set the flag: signed and unsigned magnitude compares, sign tests, an equality test against a sign-extended 8-bit immediate, a byte-lane match, and an explicit flag clear.

The result word and its valid strobe are combinational from the operands, the operation code and the current flag. The flag takes its new value on the rising clock edge when the enable is high. A surrounding pipeline supplies register contents on the operand ports and takes the result back. Storage, decoding and multiply live elsewhere.

Top module: `tflag_cmp_unit`

## Requirements
- R1: After reset (active-low `rst_n`) the flag `t_o` is 0.
- R2: Code 1 (add with carry): `res_o` = rn + rm + T modulo 2^32; T takes the carry out of bit 31.
- R3: Code 2 (add with overflow): `res_o` = rn + rm modulo 2^32; T is 1 exactly when the two's-complement sum overflows.
- R4: Code 3 (decrement-and-test): `res_o` = rn - 1 modulo 2^32; T is 1 exactly when that value is zero.
- R5: Codes 4 and 5 set T to rn >= rm and rn > rm, both signed.
- R6: Codes 6 and 7 set T to rn >= rm and rn > rm, both unsigned.
- R7: Code 8 sets T to rn > 0 signed; code 9 sets T to rn >= 0 signed.
- R8: Code 10 sets T when r0 equals the 8-bit immediate sign-extended to 32 bits.
- R9: Code 11 sets T when any of the four bytes of rn equals the byte in the same position of rm.
- R10: Code 12 forces T to 0.
- R11: `res_vld_o` is 1 only when `en` is 1 and the code is 1, 2 or 3; at other times `res_o` is 0.
- R12: T is unchanged on any edge where `en` is 0 or the code is 0, 13, 14 or 15.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| en | input | 1 | Operation enable |
| op | input | 4 | Operation code |
| rn_i | input | 32 | First operand |
| rm_i | input | 32 | Second operand |
| r0_i | input | 32 | Operand for immediate compare |
| imm_i | input | 8 | Immediate byte |
| res_o | output | 32 | Result word |
| res_vld_o | output | 1 | Result valid |
| t_o | output | 1 | T flag |

## Verification
The hardest situation to reach is an add with carry in where the incoming flag is itself the only source of the carry. In that case rn + rm is exactly all ones and T was set by an earlier operation. The stimulus builds this by first running an unsigned compare that leaves T at 1. The very next cycle then adds an all-ones pair, so that the result wraps to zero with a carry out. Byte-lane matches in a single position, and overflow at both signed extremes, are driven as directed vectors. Random traffic then draws operands from a small pool of edge values so that equality and sign boundaries recur often.

// File: rtl/tflag_pkg.sv
package tflag_pkg;
  localparam int DW = 32;
  localparam int IW = 8;

  typedef enum logic [3:0] {
    OP_NOP  = 4'd0,
    OP_ADDC = 4'd1,
    OP_ADDV = 4'd2,
    OP_DEC  = 4'd3,
    OP_SGE  = 4'd4,
    OP_SGT  = 4'd5,
    OP_UGE  = 4'd6,
    OP_UGT  = 4'd7,
    OP_POS  = 4'd8,
    OP_NNEG = 4'd9,
    OP_EQI  = 4'd10,
    OP_BYTE = 4'd11,
    OP_CLRT = 4'd12
  } tf_op_e;
endpackage

// File: rtl/tf_arith.sv
module tf_arith
  import tflag_pkg::*;
#(
  parameter int W = DW
) (
  input  logic [3:0]   op,
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  input  logic         t_in,
  output logic [W-1:0] res,
  output logic         vld,
  output logic         t_out,
  output logic         t_wr
);
  function automatic logic [W:0] sum3(input logic [W-1:0] x, input logic [W-1:0] y, input logic c);
    return {1'b0, x} + {1'b0, y} + {{W{1'b0}}, c};
  endfunction

  function automatic logic sovf(input logic [W-1:0] x, input logic [W-1:0] y, input logic [W-1:0] s);
    return (x[W-1] == y[W-1]) && (s[W-1] != x[W-1]);
  endfunction

  logic [W:0]   carry_sum;
  logic [W:0]   plain_sum;
  logic [W-1:0] dec_val;

  assign carry_sum = sum3(a, b, t_in);
  assign plain_sum = sum3(a, b, 1'b0);
  assign dec_val   = a - {{(W-1){1'b0}}, 1'b1};

  always_comb begin
    res   = '0;
    vld   = 1'b0;
    t_out = 1'b0;
    t_wr  = 1'b0;
    unique case (op)
      OP_ADDC: begin
        res = carry_sum[W-1:0]; vld = 1'b1; t_out = carry_sum[W]; t_wr = 1'b1;
      end
      OP_ADDV: begin
        res = plain_sum[W-1:0]; vld = 1'b1; t_wr = 1'b1;
        t_out = sovf(a, b, plain_sum[W-1:0]);
      end
      OP_DEC: begin
        res = dec_val; vld = 1'b1; t_wr = 1'b1; t_out = (dec_val == '0);
      end
      default: ;
    endcase
  end
endmodule

// File: rtl/tf_compare.sv
module tf_compare
  import tflag_pkg::*;
#(
  parameter int W  = DW,
  parameter int IWD = IW
) (
  input  logic [3:0]     op,
  input  logic [W-1:0]   a,
  input  logic [W-1:0]   b,
  input  logic [W-1:0]   r0,
  input  logic [IWD-1:0] imm,
  output logic           t_out,
  output logic           t_wr
);
  localparam int LANES = W / 8;

  logic [W-1:0]     diff;
  logic [LANES-1:0] lane_hit;
  logic [W-1:0]     imm_ext;

  assign diff    = a ^ b;
  assign imm_ext = {{(W-IWD){imm[IWD-1]}}, imm};

  for (genvar i = 0; i < LANES; i++) begin : g_lane
    assign lane_hit[i] = (diff[i*8 +: 8] == 8'h00);
  end

  always_comb begin
    t_out = 1'b0;
    t_wr  = 1'b1;
    unique case (op)
      OP_SGE:  t_out = $signed(a) >= $signed(b);
      OP_SGT:  t_out = $signed(a) >  $signed(b);
      OP_UGE:  t_out = a >= b;
      OP_UGT:  t_out = a >  b;
      OP_POS:  t_out = !a[W-1] && (a != '0);
      OP_NNEG: t_out = !a[W-1];
      OP_EQI:  t_out = (r0 == imm_ext);
      OP_BYTE: t_out = |lane_hit;
      OP_CLRT: t_out = 1'b0;
      default: t_wr  = 1'b0;
    endcase
  end
endmodule

// File: rtl/tf_flag_reg.sv
module tf_flag_reg (
  input  logic clk,
  input  logic rst_n,
  input  logic wr,
  input  logic d,
  output logic q
);
  always_ff @(posedge clk) begin
    if (!rst_n)  q <= 1'b0;
    else if (wr) q <= d;
  end
endmodule

// File: rtl/tflag_cmp_unit.sv
module tflag_cmp_unit
  import tflag_pkg::*;
#(
  parameter int W   = DW,
  parameter int IWD = IW
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           en,
  input  logic [3:0]     op,
  input  logic [W-1:0]   rn_i,
  input  logic [W-1:0]   rm_i,
  input  logic [W-1:0]   r0_i,
  input  logic [IWD-1:0] imm_i,
  output logic [W-1:0]   res_o,
  output logic           res_vld_o,
  output logic           t_o
);
  logic [W-1:0] arith_res;
  logic         arith_vld;
  logic         arith_t;
  logic         arith_wr;
  logic         cmp_t;
  logic         cmp_wr;
  logic         t_wr;
  logic         t_next;

  tf_arith #(.W(W)) u_arith (
    .op(op), .a(rn_i), .b(rm_i), .t_in(t_o),
    .res(arith_res), .vld(arith_vld), .t_out(arith_t), .t_wr(arith_wr)
  );

  tf_compare #(.W(W), .IWD(IWD)) u_cmp (
    .op(op), .a(rn_i), .b(rm_i), .r0(r0_i), .imm(imm_i),
    .t_out(cmp_t), .t_wr(cmp_wr)
  );

  assign t_wr   = en && (arith_wr || cmp_wr);
  assign t_next = arith_wr ? arith_t : cmp_t;

  tf_flag_reg u_flag (.clk(clk), .rst_n(rst_n), .wr(t_wr), .d(t_next), .q(t_o));

  assign res_vld_o = en && arith_vld;
  assign res_o     = res_vld_o ? arith_res : '0;
endmodule

// File: rtl/tflag_cmp_chk.sv
module tflag_cmp_chk
  import tflag_pkg::*;
#(
  parameter int W   = DW,
  parameter int IWD = IW
) (
  input logic           clk,
  input logic           rst_n,
  input logic           en,
  input logic [3:0]     op,
  input logic [W-1:0]   rn_i,
  input logic [W-1:0]   r0_i,
  input logic [IWD-1:0] imm_i,
  input logic [W-1:0]   res_o,
  input logic           res_vld_o,
  input logic           t_o
);
  // R12
  hold_when_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !en |=> $stable(t_o));
  // R10
  clear_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (en && op == OP_CLRT) |=> !t_o);
  // R11
  valid_needs_en_chk: assert property (@(posedge clk) disable iff (!rst_n)
    res_vld_o |-> en);
  // R11
  idle_result_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !res_vld_o |-> (res_o == '0));
  // R4
  dec_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (en && op == OP_DEC) |=> (t_o == ($past(rn_i) == {{(W-1){1'b0}}, 1'b1})));
  // R8
  imm_eq_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (en && op == OP_EQI) |=> (t_o == ($past(r0_i) == {{(W-IWD){$past(imm_i[IWD-1])}}, $past(imm_i)})));
endmodule

bind tflag_cmp_unit tflag_cmp_chk #(.W(W), .IWD(IWD)) u_chk (
  .clk(clk), .rst_n(rst_n), .en(en), .op(op), .rn_i(rn_i), .r0_i(r0_i),
  .imm_i(imm_i), .res_o(res_o), .res_vld_o(res_vld_o), .t_o(t_o)
);

// File: tb/tb_tflag_cmp_unit.sv
`timescale 1ns/1ps
module tb_tflag_cmp_unit;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        en = 1'b0;
  logic [3:0]  op = 4'd0;
  logic [31:0] rn = '0, rm = '0, r0 = '0;
  logic [7:0]  imm = '0;
  logic [31:0] res_o;
  logic        res_vld_o, t_o;

  int tests = 0, fails = 0;
  bit done = 0;
  bit mt = 0;

  always #2 clk = ~clk;

  tflag_cmp_unit dut (
    .clk(clk), .rst_n(rst_n), .en(en), .op(op), .rn_i(rn), .rm_i(rm),
    .r0_i(r0), .imm_i(imm), .res_o(res_o), .res_vld_o(res_vld_o), .t_o(t_o)
  );

  function automatic string tag(input bit e, input int c);
    if (!e) return "R12";
    case (c)
      1: return "R2"; 2: return "R3"; 3: return "R4";
      4, 5: return "R5"; 6, 7: return "R6"; 8, 9: return "R7";
      10: return "R8"; 11: return "R9"; 12: return "R10";
      default: return "R12";
    endcase
  endfunction

  task automatic check(input string r, input string what, input longint act, input longint exp);
    tests++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s %s actual=%0h expected=%0h", r, what, act, exp);
    end
  endtask

  task automatic step(input bit e, input int c, input logic [31:0] a, input logic [31:0] b,
                      input logic [31:0] z, input logic [7:0] im);
    longint s;
    longint sa, sb;
    logic [31:0] eres, x;
    bit evld, et;
    @(negedge clk);
    en = e; op = c[3:0]; rn = a; rm = b; r0 = z; imm = im;
    eres = 0; evld = 0; et = mt;
    sa = longint'($signed(a)); sb = longint'($signed(b));
    if (e) begin
      case (c)
        1: begin s = longint'(a) + longint'(b) + longint'(mt); eres = s[31:0]; evld = 1; et = s[32]; end
        2: begin s = sa + sb; eres = s[31:0]; evld = 1; et = (s > 64'sd2147483647) || (s < -64'sd2147483648); end
        3: begin eres = a - 1; evld = 1; et = (eres == 0); end
        4: et = sa >= sb;
        5: et = sa > sb;
        6: et = longint'(a) >= longint'(b);
        7: et = longint'(a) > longint'(b);
        8: et = sa > 0;
        9: et = sa >= 0;
        10: et = (longint'($signed(z)) == longint'($signed(im)));
        11: begin
          x = a ^ b; et = 0;
          for (int k = 0; k < 4; k++) if (((x >> (8*k)) & 32'hff) == 0) et = 1;
        end
        12: et = 0;
        default: et = mt;
      endcase
    end
    #1;
    check("R11", "res_vld", res_vld_o, evld);
    check(evld ? tag(e, c) : "R11", "res", res_o, eres);
    @(posedge clk); #1;
    check(tag(e, c), "t", t_o, et);
    mt = et;
  endtask

  function automatic logic [31:0] pick();
    case ($urandom_range(0, 7))
      0: return 32'h0;
      1: return 32'h1;
      2: return 32'hffffffff;
      3: return 32'h7fffffff;
      4: return 32'h80000000;
      5: return 32'h000000ff;
      default: return $urandom;
    endcase
  endfunction

  initial begin
    repeat (3) @(posedge clk);
    #1;
    check("R1", "t after reset", t_o, 0);
    @(negedge clk); rst_n = 1;
    // R2 carry from T alone: set T via unsigned compare, then all-ones sum
    step(1, 7, 32'h5, 32'h3, 0, 0);
    step(1, 1, 32'hfffffffe, 32'h1, 0, 0);
    step(1, 1, 32'h0, 32'h0, 0, 0);
    step(1, 1, 32'h80000000, 32'h80000000, 0, 0);
    // R3 both overflow directions and none
    step(1, 2, 32'h7fffffff, 32'h1, 0, 0);
    step(1, 2, 32'h80000000, 32'hffffffff, 0, 0);
    step(1, 2, 32'h7fffffff, 32'hffffffff, 0, 0);
    // R4
    step(1, 3, 32'h1, 0, 0, 0);
    step(1, 3, 32'h0, 0, 0, 0);
    // R5 R6 sign vs magnitude disagreement
    step(1, 4, 32'hffffffff, 32'h1, 0, 0);
    step(1, 6, 32'hffffffff, 32'h1, 0, 0);
    step(1, 5, 32'h5, 32'h5, 0, 0);
    step(1, 7, 32'h5, 32'h5, 0, 0);
    // R7
    step(1, 8, 32'h0, 0, 0, 0);
    step(1, 9, 32'h0, 0, 0, 0);
    step(1, 9, 32'h80000000, 0, 0, 0);
    // R8 negative immediate
    step(1, 10, 0, 0, 32'hffffff80, 8'h80);
    step(1, 10, 0, 0, 32'h00000080, 8'h80);
    // R9 single-lane matches in each position
    for (int k = 0; k < 4; k++)
      step(1, 11, 32'h11223344, 32'h11223344 ^ (32'hffffffff & ~(32'hff << (8*k))), 0, 0);
    step(1, 11, 32'h11223344, 32'heeddccbb, 0, 0);
    // R12 idle and reserved codes hold T, R10 clear
    step(1, 9, 32'h1, 0, 0, 0);
    step(0, 12, 0, 0, 0, 0);
    step(1, 0, 0, 0, 0, 0);
    step(1, 14, 0, 0, 0, 0);
    step(1, 12, 0, 0, 0, 0);
    step(0, 1, 32'hffffffff, 32'h1, 0, 0);
    for (int i = 0; i < 600; i++)
      step($urandom_range(0, 7) != 0, $urandom_range(0, 15), pick(), pick(), pick(), 8'($urandom));
    done = 1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      tests++; fails++;
      $display("FAIL watchdog expired");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end
endmodule